// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block buffers words between two unrelated clock domains. A producer writes on `wclk`, a consumer reads on `rclk`. The storage holds 2^AW words of DW bits; the defaults are 2048 words of 9 bits. Both pointers are one bit wider than the address. Each pointer crosses to the other domain as a Gray code through a two-stage synchronizer. Four active-low status flags report the fill level: empty, full, almost-empty and almost-full. Each flag is computed and registered in the domain that consumes it.

The data interface uses plain enable pins, not a valid/ready handshake, so back-pressure is flag-driven:
- A write attempted while `full_n` is low is dropped without effect.
- A read attempted while `empty_n` is low is dropped, and `dout` holds its value.
- A flag raised by activity in the other domain can lag by the synchronizer delay plus one edge of its own clock.

The level of `wr_aux` at reset fixes its role until the next reset:
- **Held high at reset:** `wr_aux` is a second write enable.
- **Held low at reset:** `wr_aux` becomes a load select for two threshold registers.

The two threshold registers are an almost-empty offset and an almost-full offset. They are written through `din` and read back through `dout`. Each register is AW bits wide. It is reached as a low part, taken from data bits DW-1..0, and a high part of AW-DW bits, taken from the lowest data bits. AW must exceed DW. The threshold registers are meant to be programmed while the queue is idle and are treated as static by the read domain.

Top module: `dcfifo_prog`

## Requirements
- R1: Words leave in the order they were accepted. With both read enables held low, the first word written into an empty queue is on `dout` at the first `rclk` edge after `empty_n` is seen high.
- R2: `empty_n` is low exactly when the read side sees no stored word. While it is low, a read request neither advances the read pointer nor changes `dout`.
- R3: `full_n` goes low when 2^AW words are stored. While it is low, write requests are dropped and stored data is not overwritten.
- R4: `almost_empty_n` is low when the stored count is at most the almost-empty offset.
- R5: `almost_full_n` is low when the stored count is at least 2^AW minus the almost-full offset.
- R6: Reset has the following effects:
  - Both pointers are cleared.
  - `empty_n` and `almost_empty_n` are driven low.
  - `full_n` and `almost_full_n` are driven high.
  - `dout` is 0.
  - Both offsets become 7.
- R7: If `wr_aux` is high during reset, a word is accepted only on a `wclk` edge where `wr_en_n` is low and `wr_aux` is high.
- R8: If `wr_aux` is low during reset, a `wclk` edge with `wr_en_n` low and `wr_aux` low writes one threshold register part and stores no word. Successive writes step cyclically through four parts:
  - code 0: almost-empty low part
  - code 1: almost-empty high part
  - code 2: almost-full low part
  - code 3: almost-full high part

  A `wclk` edge with `wr_en_n` low and `wr_aux` high stores a word.
- R9: In load mode, an `rclk` edge with `wr_aux` low and both read enables low puts the next threshold register part on `dout`, with unused upper bits 0. Read-back follows the same cyclic order as R8, uses a pointer separate from the write pointer, and does not consume a stored word.
- R10: While `out_en_n` is high, `dout` is all zeros.
- R11: A word is read only when both `rd_en_n` and `rd_en2_n` are low. In load mode `wr_aux` must also be high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, common to both domains |
| din | input | DW | Write data, or threshold register part in load mode |
| wr_en_n | input | 1 | Active-low write enable |
| wr_aux | input | 1 | Second write enable (active high), or threshold load select (active low) in load mode |
| rd_en_n | input | 1 | First active-low read enable |
| rd_en2_n | input | 1 | Second active-low read enable |
| out_en_n | input | 1 | Active-low output enable; high forces `dout` to zero |
| dout | output | DW | Read data or threshold read-back |
| empty_n | output | 1 | Low when empty (read clock) |
| full_n | output | 1 | Low when full (write clock) |
| almost_empty_n | output | 1 | Low when count is at or below the almost-empty offset (read clock) |
| almost_full_n | output | 1 | Low when count reaches the almost-full threshold (write clock) |

## Verification
A corrupted pointer or a bad Gray conversion shows up in two ways at the ports. It shifts the level at which a flag flips, and it misorders or repeats read data. Within one burst, such a fault appears as a flag mismatch a few cycles after the burst settles. A wrong threshold-register selector appears as a read-back value out of cyclic order on the very next access. It also shows as a flag that flips at the wrong count. A mode latch that is inverted or not held appears as words that are stored, or not stored, against the level `wr_aux` had at reset. `empty_n` then reports the mistake one synchronizer delay later.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  // selector codes for the threshold register parts, in access order
  typedef enum logic [1:0] {
    OFS_AE_LO = 2'd0,
    OFS_AE_HI = 2'd1,
    OFS_AF_LO = 2'd2,
    OFS_AF_HI = 2'd3
  } ofs_sel_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DW = 9,
  parameter int AW = 11
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int DW       = 9,
  parameter int AW       = 11,
  parameter int OFS_INIT = 7
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic          wr_aux,
  input  logic [DW-1:0] din,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   wgray,
  output logic [AW:0]   wbin,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [AW-1:0] ae_ofs,
  output logic [AW-1:0] af_ofs,
  output logic          ld_mode,
  output logic          full_n,
  output logic          af_n
);
  localparam int HW    = AW - DW;
  localparam int DEPTH = 1 << AW;

  logic [AW:0]   wbin_q, wgray_q, wbin_nx, wgray_nx, rbin_s, cnt_nx, af_thr;
  logic          full_n_q, af_n_q, ld_q, push, ofs_wr, full_nx;
  logic [1:0]    wsel_q;
  logic [AW-1:0] ae_q, af_q;

  // role of wr_aux is captured while reset is held
  always_ff @(posedge wclk) begin
    if (!rst_n) ld_q <= ~wr_aux;
  end

  always_comb begin
    rbin_s[AW] = rgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
  end

  assign push     = !wr_en_n && wr_aux && full_n_q;
  assign ofs_wr   = ld_q && !wr_en_n && !wr_aux;
  assign wbin_nx  = wbin_q + (AW+1)'(push);
  assign wgray_nx = wbin_nx ^ (wbin_nx >> 1);
  assign cnt_nx   = wbin_nx - rbin_s;
  assign af_thr   = (AW+1)'(DEPTH) - {1'b0, af_q};
  assign full_nx  = wgray_nx != {~rgray_s[AW:AW-1], rgray_s[AW-2:0]};

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q   <= '0;
      wgray_q  <= '0;
      full_n_q <= 1'b1;
      af_n_q   <= 1'b1;
    end else begin
      wbin_q   <= wbin_nx;
      wgray_q  <= wgray_nx;
      full_n_q <= full_nx;
      af_n_q   <= !(cnt_nx >= af_thr);
    end
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      ae_q   <= AW'(OFS_INIT);
      af_q   <= AW'(OFS_INIT);
      wsel_q <= OFS_AE_LO;
    end else if (ofs_wr) begin
      case (wsel_q)
        OFS_AE_LO: ae_q[DW-1:0]  <= din;
        OFS_AE_HI: ae_q[AW-1:DW] <= din[HW-1:0];
        OFS_AF_LO: af_q[DW-1:0]  <= din;
        default:   af_q[AW-1:DW] <= din[HW-1:0];
      endcase
      wsel_q <= wsel_q + 2'd1;
    end
  end

  assign wgray     = wgray_q;
  assign wbin      = wbin_q;
  assign mem_we    = push;
  assign mem_waddr = wbin_q[AW-1:0];
  assign ae_ofs    = ae_q;
  assign af_ofs    = af_q;
  assign ld_mode   = ld_q;
  assign full_n    = full_n_q;
  assign af_n      = af_n_q;
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int DW = 9,
  parameter int AW = 11
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          rd_en_n,
  input  logic          rd_en2_n,
  input  logic          wr_aux,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] mem_rdata,
  input  logic [AW-1:0] ae_ofs,
  input  logic [AW-1:0] af_ofs,
  output logic [AW:0]   rgray,
  output logic [AW:0]   rbin,
  output logic [AW-1:0] mem_raddr,
  output logic [DW-1:0] q,
  output logic          empty_n,
  output logic          ae_n
);
  logic [AW:0]   rbin_q, rgray_q, rbin_nx, rgray_nx, wbin_s, cnt_nx;
  logic          empty_n_q, ae_n_q, ld_q, both_en, ofs_rd, pop;
  logic [1:0]    rsel_q;
  logic [DW-1:0] q_q;

  always_ff @(posedge rclk) begin
    if (!rst_n) ld_q <= ~wr_aux;
  end

  always_comb begin
    wbin_s[AW] = wgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
  end

  assign both_en  = !rd_en_n && !rd_en2_n;
  assign ofs_rd   = ld_q && !wr_aux && both_en;
  assign pop      = both_en && !(ld_q && !wr_aux) && empty_n_q;
  assign rbin_nx  = rbin_q + (AW+1)'(pop);
  assign rgray_nx = rbin_nx ^ (rbin_nx >> 1);
  assign cnt_nx   = wbin_s - rbin_nx;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q    <= '0;
      rgray_q   <= '0;
      empty_n_q <= 1'b0;
      ae_n_q    <= 1'b0;
    end else begin
      rbin_q    <= rbin_nx;
      rgray_q   <= rgray_nx;
      empty_n_q <= rgray_nx != wgray_s;
      ae_n_q    <= cnt_nx > {1'b0, ae_ofs};
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= '0;
      rsel_q <= OFS_AE_LO;
    end else if (ofs_rd) begin
      case (rsel_q)
        OFS_AE_LO: q_q <= ae_ofs[DW-1:0];
        OFS_AE_HI: q_q <= DW'(ae_ofs[AW-1:DW]);
        OFS_AF_LO: q_q <= af_ofs[DW-1:0];
        default:   q_q <= DW'(af_ofs[AW-1:DW]);
      endcase
      rsel_q <= rsel_q + 2'd1;
    end else if (pop) begin
      q_q <= mem_rdata;
    end
  end

  assign rgray     = rgray_q;
  assign rbin      = rbin_q;
  assign mem_raddr = rbin_q[AW-1:0];
  assign q         = q_q;
  assign empty_n   = empty_n_q;
  assign ae_n      = ae_n_q;
endmodule

// File: rtl/dcfifo_prog.sv
module dcfifo_prog #(
  parameter int DW       = 9,
  parameter int AW       = 11,
  parameter int OFS_INIT = 7
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          wr_en_n,
  input  logic          wr_aux,
  input  logic          rd_en_n,
  input  logic          rd_en2_n,
  input  logic          out_en_n,
  output logic [DW-1:0] dout,
  output logic          empty_n,
  output logic          full_n,
  output logic          almost_empty_n,
  output logic          almost_full_n
);
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s, w_ptr, r_ptr;
  logic          mem_we, ld_mode_w;
  logic [AW-1:0] mem_waddr, mem_raddr, ae_ofs, af_ofs;
  logic [DW-1:0] mem_rdata, q;

  dcf_wr_side #(.DW(DW), .AW(AW), .OFS_INIT(OFS_INIT)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wr_en_n(wr_en_n), .wr_aux(wr_aux), .din(din),
    .rgray_s(rgray_s), .wgray(wgray), .wbin(w_ptr), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .ld_mode(ld_mode_w),
    .full_n(full_n), .af_n(almost_full_n)
  );

  dcf_rd_side #(.DW(DW), .AW(AW)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .rd_en_n(rd_en_n), .rd_en2_n(rd_en2_n),
    .wr_aux(wr_aux), .wgray_s(wgray_s), .mem_rdata(mem_rdata), .ae_ofs(ae_ofs),
    .af_ofs(af_ofs), .rgray(rgray), .rbin(r_ptr), .mem_raddr(mem_raddr), .q(q),
    .empty_n(empty_n), .ae_n(almost_empty_n)
  );

  dcf_sync #(.W(AW+1)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
  dcf_sync #(.W(AW+1)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  dcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(mem_we), .waddr(mem_waddr), .wdata(din),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  assign dout = out_en_n ? '0 : q;
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
  parameter int AW = 11
) (
  input logic        wclk,
  input logic        rclk,
  input logic        rst_n,
  input logic        wr_en_n,
  input logic        wr_aux,
  input logic        empty_n,
  input logic        full_n,
  input logic        almost_empty_n,
  input logic        almost_full_n,
  input logic        ld_mode,
  input logic [AW:0] w_ptr,
  input logic [AW:0] r_ptr
);
  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(w_ptr));

  assert_no_underflow_R2: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(r_ptr));

  assert_wr_step_R1: assert property (@(posedge wclk) disable iff (!rst_n)
    (AW+1)'(w_ptr - $past(w_ptr)) <= (AW+1)'(1));

  assert_rd_step_R1: assert property (@(posedge rclk) disable iff (!rst_n)
    (AW+1)'(r_ptr - $past(r_ptr)) <= (AW+1)'(1));

  assert_full_in_af_R5: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> !almost_full_n);

  assert_empty_in_ae_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !almost_empty_n);

  assert_load_no_push_R8: assert property (@(posedge wclk) disable iff (!rst_n)
    (ld_mode && !wr_en_n && !wr_aux) |=> $stable(w_ptr));

  assert_gate_no_push_R7: assert property (@(posedge wclk) disable iff (!rst_n)
    (!ld_mode && !wr_aux) |=> $stable(w_ptr));
endmodule

bind dcfifo_prog dcf_chk #(.AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en_n(wr_en_n), .wr_aux(wr_aux),
  .empty_n(empty_n), .full_n(full_n), .almost_empty_n(almost_empty_n),
  .almost_full_n(almost_full_n), .ld_mode(ld_mode_w), .w_ptr(w_ptr), .r_ptr(r_ptr)
);

// File: tb/tb_dcfifo_prog.sv
module tb_dcfifo_prog;
  localparam int DW = 9;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic wr_en_n = 1'b1, wr_aux = 1'b1, rd_en_n = 1'b1, rd_en2_n = 1'b1, out_en_n = 1'b0;
  logic [DW-1:0] dout;
  logic empty_n, full_n, almost_empty_n, almost_full_n;

  int total = 0, bad = 0, dval = 1;
  bit done = 1'b0;
  int model[$];

  always #2 wclk = ~wclk;
  always #3 rclk = ~rclk;

  dcfifo_prog #(.DW(DW), .AW(AW)) dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .din(din), .wr_en_n(wr_en_n),
    .wr_aux(wr_aux), .rd_en_n(rd_en_n), .rd_en2_n(rd_en2_n), .out_en_n(out_en_n),
    .dout(dout), .empty_n(empty_n), .full_n(full_n),
    .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
  );

  // {is_read, count, expected {empty_n, almost_empty_n, almost_full_n, full_n}}
  localparam logic [16:0] STEPS [12] = '{
    {1'b0, 12'd1,    4'b1011}, {1'b0, 12'd6,    4'b1011},
    {1'b0, 12'd1,    4'b1111}, {1'b0, 12'd2032, 4'b1111},
    {1'b0, 12'd1,    4'b1101}, {1'b0, 12'd7,    4'b1100},
    {1'b0, 12'd3,    4'b1100}, {1'b1, 12'd1,    4'b1101},
    {1'b1, 12'd7,    4'b1111}, {1'b1, 12'd2032, 4'b1111},
    {1'b1, 12'd1,    4'b1011}, {1'b1, 12'd7,    4'b0011}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge wclk);
    repeat (8) @(negedge rclk);
  endtask

  task automatic do_reset(input logic aux);
    rst_n = 1'b0; wr_aux = aux; wr_en_n = 1'b1; rd_en_n = 1'b1; rd_en2_n = 1'b1;
    repeat (4) @(negedge wclk);
    repeat (4) @(negedge rclk);
    model.delete();
    @(negedge wclk) rst_n = 1'b1;
    wr_aux = 1'b1;
    settle();
  endtask

  task automatic wr_words(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      din = DW'(dval); wr_en_n = 1'b0;
      if (model.size() < DEPTH) model.push_back(dval & 9'h1ff);
      dval = dval + 3;
    end
    @(negedge wclk) wr_en_n = 1'b1;
  endtask

  task automatic rd_words(input int n, input string req);
    int e;
    @(negedge rclk) begin rd_en_n = 1'b0; rd_en2_n = 1'b0; end
    for (int i = 0; i < n; i++) begin
      @(negedge rclk);
      if (i == n - 1) begin rd_en_n = 1'b1; rd_en2_n = 1'b1; end
      e = model.pop_front();
      chk(req, 32'(dout), 32'(e));
    end
  endtask

  task automatic wr_ofs(input logic [DW-1:0] v);
    @(negedge wclk) begin din = v; wr_aux = 1'b0; wr_en_n = 1'b0; end
    @(negedge wclk) begin wr_en_n = 1'b1; wr_aux = 1'b1; end
  endtask

  task automatic chk_flags(input logic [3:0] f);
    chk("R2 empty_n", 32'(empty_n), 32'(f[3]));
    chk("R4 almost_empty_n", 32'(almost_empty_n), 32'(f[2]));
    chk("R5 almost_full_n", 32'(almost_full_n), 32'(f[1]));
    chk("R3 full_n", 32'(full_n), 32'(f[0]));
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] hold;
    int rb_exp [5];
    int e;
    bit seen;

    // R6: reset state
    do_reset(1'b1);
    chk_flags(4'b0011);
    chk("R6 dout", 32'(dout), 32'd0);

    // table walk, default offsets of 7 (R6, R1, R2-R5)
    for (int s = 0; s < 12; s++) begin
      if (STEPS[s][16]) rd_words(int'(STEPS[s][15:4]), "R1 order");
      else wr_words(int'(STEPS[s][15:4]));
      settle();
      chk_flags(STEPS[s][3:0]);
    end

    // R2: reads on empty leave dout unchanged
    hold = dout;
    @(negedge rclk) begin rd_en_n = 1'b0; rd_en2_n = 1'b0; end
    repeat (3) @(negedge rclk);
    rd_en_n = 1'b1; rd_en2_n = 1'b1;
    chk("R2 dout on empty read", 32'(dout), 32'(hold));

    // R7: second enable low blocks writes
    @(negedge wclk) begin din = 9'h0aa; wr_en_n = 1'b0; wr_aux = 1'b0; end
    @(negedge wclk) begin wr_en_n = 1'b1; wr_aux = 1'b1; end
    settle();
    chk("R7 gated write", 32'(empty_n), 32'd0);

    // R11: one read enable alone reads nothing
    wr_words(1);
    settle();
    hold = dout;
    @(negedge rclk) rd_en_n = 1'b0;
    repeat (3) @(negedge rclk);
    rd_en_n = 1'b1;
    settle();
    chk("R11 single enable dout", 32'(dout), 32'(hold));
    chk("R11 single enable empty_n", 32'(empty_n), 32'd1);
    rd_words(1, "R11 both enables");

    // R10: output enable
    @(negedge rclk) out_en_n = 1'b1;
    #1 chk("R10 dout off", 32'(dout), 32'd0);
    @(negedge rclk) out_en_n = 1'b0;

    // R1: first word visible one rclk edge after empty_n rises
    settle();
    @(negedge rclk) begin rd_en_n = 1'b0; rd_en2_n = 1'b0; end
    wr_words(1);
    seen = 1'b0;
    for (int k = 0; k < 40 && !seen; k++) begin
      @(negedge rclk);
      if (empty_n) seen = 1'b1;
    end
    @(negedge rclk);
    rd_en_n = 1'b1; rd_en2_n = 1'b1;
    e = model.pop_front();
    chk("R1 first word timing", 32'(dout), 32'(e));
    settle();
    chk("R1 empty after single", 32'(empty_n), 32'd0);

    // load mode
    do_reset(1'b0);
    chk_flags(4'b0011);
    wr_ofs(9'd3); wr_ofs(9'd0); wr_ofs(9'd5); wr_ofs(9'd1);
    settle();
    chk("R8 offset write stores no word", 32'(empty_n), 32'd0);
    wr_words(4);
    settle();
    chk("R8 load-mode word write", 32'(empty_n), 32'd1);
    rb_exp = '{3, 0, 5, 1, 3};
    @(negedge rclk) begin wr_aux = 1'b0; rd_en_n = 1'b0; rd_en2_n = 1'b0; end
    for (int i = 0; i < 5; i++) begin
      @(negedge rclk);
      if (i == 4) begin rd_en_n = 1'b1; rd_en2_n = 1'b1; wr_aux = 1'b1; end
      chk("R9 readback", 32'(dout), 32'(rb_exp[i]));
    end
    rd_words(4, "R9 readback consumed nothing");
    settle();
    wr_words(3);
    settle();
    chk("R4 count 3 offset 3", 32'(almost_empty_n), 32'd0);
    wr_words(1);
    settle();
    chk("R4 count 4 offset 3", 32'(almost_empty_n), 32'd1);
    wr_words(1526);
    settle();
    chk("R5 count 1530 offset 517", 32'(almost_full_n), 32'd1);
    wr_words(1);
    settle();
    chk("R5 count 1531 offset 517", 32'(almost_full_n), 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule